// File: doc/BRIEF.md
# Stepper Coil PWM Bank

This block generates the coil waveforms for a set of small stepper motors. It contains a row of identical PWM channels. All of them compare against one shared free-running counter, so every output in the bank works on the same period. Software sets each channel's pulse width, where the pulse sits in the period (left, right or centred), a phase delay and a dither bit. It also picks which of the channel's two pins carries the pulse. Software then writes a fresh width each step to get full, half or micro-stepping.

New channel settings are held in a shadow copy and only take effect when the counter wraps, so a pulse is never cut short or doubled inside a period. Two conditions raise interrupts. The first is a counter wrap. The second is a short-circuit report on any output pin; these reports pass through a two-flop synchroniser and latch into sticky flags.

Registers are reached over a single-cycle write strobe with a combinational read port. The address map is:
- address 0: control (run, wrap interrupt enable, short interrupt enable)
- address 1: wrap flag
- address 2: short flags
- address 8 upward: one configuration word per channel

Top module: `smpwm_top`

## Requirements
- R1: After reset all pins and both interrupts are low, and every register reads zero.
- R2: The control register holds run in bit 0, the wrap interrupt enable in bit 1 and the short interrupt enable in bit 2. While run is set, the 11-bit counter steps by one each cycle and wraps from 2047 to 0, so the period is 2048 cycles. While run is clear, the counter sits at 0 and all pins are low.
- R3: Channel k drives pins 2k (A) and 2k+1 (B). Its drive field, bits 15:14 of the channel word, selects where the pulse goes: 1 puts it on A with B low, 2 puts it on B with A low, and 0 or 3 hold both pins low.
- R4: The effective width d is the duty field (bits 10:0), plus one in dithered periods. The align field is bits 13:12. With align 0 (or 3), the pulse is high while phase < d.
- R5: With align 1, the pulse is high while phase >= 2048 - d.
- R6: With align 2, the pulse is high while lo <= phase < lo + d, where lo = floor((2048 - d) / 2).
- R7: The phase is (counter - delay) mod 2048, where delay is bits 26:16 of the channel word.
- R8: When the dither bit (bit 11) is set, d alternates between duty and duty + 1 on successive periods. The first period after reset uses duty.
- R9: A channel write while running takes effect in the cycle after the next wrap. While stopped, it takes effect one cycle after the write. A read always returns the last word written.
- R10: The wrap flag (address 1, bit 0) is set in the cycle after the counter goes from 2047 to 0. Writing a one to that bit clears it; a wrap in the same cycle wins. The wrap interrupt is the flag ANDed with its enable.
- R11: Short input bit p reaches sticky flag bit p (address 2) three clock edges after it is sampled high. Writing ones to address 2 clears the corresponding flags; a new report in the same cycle wins.
- R12: The short interrupt is high when any short flag is set and the short interrupt enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| short_i | input | 24 | Short-circuit reports, one per pin |
| pin_o | output | 24 | Coil drive pins, pair 2k/2k+1 per channel |
| irq_ovf_o | output | 1 | Counter wrap interrupt |
| irq_short_o | output | 1 | Short-circuit interrupt |

## Verification
The bench programs widths at the extremes: zero with dither, which must give one high cycle in odd periods, and 2047 with dither, which must hold the pin high for the whole period. A design that mishandles the carry into the twelfth bit would show a one-cycle gap or a missing pulse. It uses a delay that pushes the pulse across the wrap point, where a subtraction without modulo would lose the tail of the pulse. It checks the exact first high cycle of a centred pulse, where an off-by-one in the centre offset shows up. It rewrites a duty value mid-period and confirms that the old width holds until the wrap; a missing shadow copy would glitch the pin at once. Finally, it counts the edges from a short report to its flag, which catches a design that drops or adds a synchroniser stage.

// File: rtl/smpwm_pkg.sv
package smpwm_pkg;

    localparam int CNT_W   = 11;
    localparam int BUS_W   = 32;
    localparam int CFG_PAD = BUS_W - 2 * CNT_W - 5;

    typedef enum logic [1:0] {
        ALN_LEFT   = 2'd0,
        ALN_RIGHT  = 2'd1,
        ALN_CENTRE = 2'd2,
        ALN_SPARE  = 2'd3
    } align_e;

    typedef enum logic [1:0] {
        DRV_OFF   = 2'd0,
        DRV_A     = 2'd1,
        DRV_B     = 2'd2,
        DRV_IDLE  = 2'd3
    } drive_e;

    typedef struct packed {
        logic [CFG_PAD-1:0] pad;
        logic [CNT_W-1:0]   delay;
        drive_e             drive;
        align_e             align;
        logic               dither;
        logic [CNT_W-1:0]   duty;
    } chan_cfg_t;

    // Decide whether a pulse of width d is active at the given phase.
    function automatic logic pulse_on(input logic [CNT_W-1:0] phase,
                                      input logic [CNT_W:0]   d,
                                      input align_e           al);
        logic [CNT_W:0] full;
        logic [CNT_W:0] p;
        logic [CNT_W:0] lo;
        logic           hit;
        full = {1'b1, {CNT_W{1'b0}}};
        p    = {1'b0, phase};
        lo   = (full - d) >> 1;
        case (al)
            ALN_RIGHT:  hit = (p >= full - d);
            ALN_CENTRE: hit = (p >= lo) && (p < lo + d);
            default:    hit = (p < d);
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/smpwm_timebase.sv
module smpwm_timebase
    import smpwm_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             parity_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    assign wrap_o = run_i && (cnt_o == CNT_TOP);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_o    <= '0;
            parity_o <= 1'b0;
        end else begin
            if (run_i) cnt_o <= cnt_o + 1'b1;
            else       cnt_o <= '0;
            if (wrap_o) parity_o <= ~parity_o;
        end
    end

endmodule

// File: rtl/smpwm_channel.sv
module smpwm_channel
    import smpwm_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic             load_i,
    input  logic             wr_i,
    input  chan_cfg_t        wcfg_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             parity_i,
    output chan_cfg_t        shadow_o,
    output logic             pin_a_o,
    output logic             pin_b_o
);

    chan_cfg_t        act_q;
    logic [CNT_W-1:0] phase;
    logic [CNT_W:0]   deff;
    logic             on;
    logic             unused_pad;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shadow_o <= '0;
            act_q    <= '0;
        end else begin
            if (wr_i)   shadow_o <= wcfg_i;
            if (load_i) act_q    <= shadow_o;
        end
    end

    always_comb begin
        phase   = cnt_i - act_q.delay;
        deff    = {1'b0, act_q.duty} + {{CNT_W{1'b0}}, act_q.dither & parity_i};
        on      = run_i && pulse_on(phase, deff, act_q.align);
        pin_a_o = on && (act_q.drive == DRV_A);
        pin_b_o = on && (act_q.drive == DRV_B);
    end

    assign unused_pad = ^act_q.pad;

endmodule

// File: rtl/smpwm_fault.sv
module smpwm_fault #(
    parameter int NPIN = 24
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NPIN-1:0] short_i,
    input  logic [NPIN-1:0] clr_i,
    output logic [NPIN-1:0] sync_o,
    output logic [NPIN-1:0] flags_o
);

    logic [NPIN-1:0] meta_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q  <= '0;
            sync_o  <= '0;
            flags_o <= '0;
        end else begin
            meta_q  <= short_i;
            sync_o  <= meta_q;
            flags_o <= (flags_o & ~clr_i) | sync_o;
        end
    end

endmodule

// File: rtl/smpwm_top.sv
module smpwm_top
    import smpwm_pkg::*;
#(
    parameter int NCH = 12,
    parameter int AW  = 5
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               bus_wr_i,
    input  logic [AW-1:0]      bus_addr_i,
    input  logic [BUS_W-1:0]   bus_wdata_i,
    output logic [BUS_W-1:0]   bus_rdata_o,
    input  logic [2*NCH-1:0]   short_i,
    output logic [2*NCH-1:0]   pin_o,
    output logic               irq_ovf_o,
    output logic               irq_short_o
);

    localparam int NPIN    = 2 * NCH;
    localparam int CH_BASE = 8;
    localparam logic [AW-1:0] ADDR_CTRL  = AW'(0);
    localparam logic [AW-1:0] ADDR_STAT  = AW'(1);
    localparam logic [AW-1:0] ADDR_SHORT = AW'(2);

    logic             run_q;
    logic             ovf_ie_q;
    logic             sc_ie_q;
    logic             ovf_flag_q;
    logic [CNT_W-1:0] cnt;
    logic             parity;
    logic             wrap;
    logic             load;
    logic [NPIN-1:0]  sc_sync;
    logic [NPIN-1:0]  sc_flags;
    logic [NPIN-1:0]  sc_clr;
    chan_cfg_t        shadow_w [NCH];

    assign load   = wrap || !run_q;
    assign sc_clr = (bus_wr_i && bus_addr_i == ADDR_SHORT) ? bus_wdata_i[NPIN-1:0] : '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q      <= 1'b0;
            ovf_ie_q   <= 1'b0;
            sc_ie_q    <= 1'b0;
            ovf_flag_q <= 1'b0;
        end else begin
            if (bus_wr_i && bus_addr_i == ADDR_CTRL) begin
                run_q    <= bus_wdata_i[0];
                ovf_ie_q <= bus_wdata_i[1];
                sc_ie_q  <= bus_wdata_i[2];
            end
            if (wrap)
                ovf_flag_q <= 1'b1;
            else if (bus_wr_i && bus_addr_i == ADDR_STAT && bus_wdata_i[0])
                ovf_flag_q <= 1'b0;
        end
    end

    smpwm_timebase u_tb (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .run_i    (run_q),
        .cnt_o    (cnt),
        .parity_o (parity),
        .wrap_o   (wrap)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic ch_wr;
        assign ch_wr = bus_wr_i && (bus_addr_i == AW'(CH_BASE + k));
        smpwm_channel u_ch (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .run_i    (run_q),
            .load_i   (load),
            .wr_i     (ch_wr),
            .wcfg_i   (chan_cfg_t'(bus_wdata_i)),
            .cnt_i    (cnt),
            .parity_i (parity),
            .shadow_o (shadow_w[k]),
            .pin_a_o  (pin_o[2*k]),
            .pin_b_o  (pin_o[2*k+1])
        );
    end

    smpwm_fault #(.NPIN(NPIN)) u_flt (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .short_i (short_i),
        .clr_i   (sc_clr),
        .sync_o  (sc_sync),
        .flags_o (sc_flags)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_CTRL:  bus_rdata_o[2:0] = {sc_ie_q, ovf_ie_q, run_q};
            ADDR_STAT:  bus_rdata_o[0] = ovf_flag_q;
            ADDR_SHORT: bus_rdata_o[NPIN-1:0] = sc_flags;
            default:    bus_rdata_o = '0;
        endcase
        for (int k = 0; k < NCH; k++) begin
            if (bus_addr_i == AW'(CH_BASE + k)) bus_rdata_o = shadow_w[k];
        end
    end

    assign irq_ovf_o   = ovf_flag_q && ovf_ie_q;
    assign irq_short_o = (|sc_flags) && sc_ie_q;

endmodule

// File: rtl/smpwm_checker.sv
module smpwm_checker #(
    parameter int NPIN  = 24,
    parameter int CNT_W = 11
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [NPIN-1:0]  pins,
    input logic             ovf_flag,
    input logic             irq_ovf,
    input logic             irq_short,
    input logic [NPIN-1:0]  sc_sync,
    input logic [NPIN-1:0]  sc_flags
);

    localparam logic [NPIN-1:0]  EVEN_MASK = {(NPIN/2){2'b01}};
    localparam logic [CNT_W-1:0] CNT_TOP   = '1;

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(run) |-> cnt == CNT_W'($past(cnt) + 1'b1)); // R2

    AST_STOP_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
        !run |-> pins == '0); // R2

    AST_PAIR_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        (pins & (pins >> 1) & EVEN_MASK) == '0); // R3

    AST_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (run && cnt == CNT_TOP) |=> ovf_flag); // R10

    AST_IRQ_OVF_SRC: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_ovf |-> ovf_flag); // R10

    AST_SHORT_SRC: assert property (@(posedge clk_i) disable iff (rst_i)
        ((sc_flags & ~$past(sc_flags)) & ~$past(sc_sync)) == '0); // R11

    AST_IRQ_SHORT_SRC: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_short |-> sc_flags != '0); // R12

endmodule

bind smpwm_top smpwm_checker #(.NPIN(NPIN), .CNT_W(smpwm_pkg::CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .run       (run_q),
    .cnt       (cnt),
    .pins      (pin_o),
    .ovf_flag  (ovf_flag_q),
    .irq_ovf   (irq_ovf_o),
    .irq_short (irq_short_o),
    .sc_sync   (sc_sync),
    .sc_flags  (sc_flags)
);

// File: tb/sim_smpwm_top.sv
module sim_smpwm_top;

    localparam int NCH  = 12;
    localparam int NPIN = 24;
    localparam int PER  = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr;
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [23:0] sh;
    logic [23:0] pins;
    logic        irq_o;
    logic        irq_s;

    always #5 clk = ~clk;

    smpwm_top u0 (
        .clk_i       (clk),
        .rst_i       (rst),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .short_i     (sh),
        .pin_o       (pins),
        .irq_ovf_o   (irq_o),
        .irq_short_o (irq_s)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    int    hc [NPIN];

    // Reference model state
    int        m_cnt;
    bit        m_par, m_run, m_oie, m_sie, m_ovf, m_wrap;
    bit [31:0] m_sh  [NCH];
    bit [31:0] m_act [NCH];
    bit [23:0] m_s1, m_s2, m_fl;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_par = 0; m_run = 0; m_oie = 0; m_sie = 0; m_ovf = 0;
            m_s1 = 0; m_s2 = 0; m_fl = 0;
            for (int k = 0; k < NCH; k++) begin m_sh[k] = 0; m_act[k] = 0; end
        end else begin
            m_wrap = m_run && (m_cnt == PER - 1);
            for (int k = 0; k < NCH; k++)
                if (m_wrap || !m_run) m_act[k] = m_sh[k];
            m_cnt = m_run ? (m_cnt + 1) % PER : 0;
            if (m_wrap) m_par = !m_par;
            m_fl = (m_fl & ~((wr && addr == 2) ? wdata[23:0] : 24'h0)) | m_s2;
            m_s2 = m_s1;
            m_s1 = sh;
            if (m_wrap) m_ovf = 1;
            else if (wr && addr == 1 && wdata[0]) m_ovf = 0;
            if (wr && addr == 0) begin
                m_run = wdata[0]; m_oie = wdata[1]; m_sie = wdata[2];
            end
            if (wr && addr >= 8 && addr < 8 + NCH) m_sh[addr - 8] = wdata;
        end
    end

    function automatic bit exp_pin(int p);
        bit [31:0] c;
        int duty, al, dr, dl, d, ph, lo;
        c    = m_act[p / 2];
        duty = int'(c[10:0]);
        al   = int'(c[13:12]);
        dr   = int'(c[15:14]);
        dl   = int'(c[26:16]);
        if (!m_run) return 0;
        if ((p % 2 == 0) && dr != 1) return 0;
        if ((p % 2 == 1) && dr != 2) return 0;
        d  = duty + ((c[11] && m_par) ? 1 : 0);
        ph = (m_cnt - dl + PER) % PER;
        if (al == 1) return ph >= PER - d;
        if (al == 2) begin
            lo = (PER - d) / 2;
            return (ph >= lo) && (ph < lo + d);
        end
        return ph < d;
    endfunction

    function automatic bit [31:0] exp_rd(int a);
        if (a == 0) return {29'h0, m_sie, m_oie, m_run};
        if (a == 1) return {31'h0, m_ovf};
        if (a == 2) return {8'h0, m_fl};
        if (a >= 8 && a < 8 + NCH) return m_sh[a - 8];
        return 32'h0;
    endfunction

    function automatic bit [31:0] cfg(int duty, bit dith, int al, int dr, int dl);
        return {5'h0, 11'(dl), 2'(dr), 2'(al), dith, 11'(duty)};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            logic [23:0] ep;
            for (int p = 0; p < NPIN; p++) ep[p] = exp_pin(p);
            chk(cur_req, "pins", {8'h0, pins}, {8'h0, ep});
            chk("R10", "irq_ovf", {31'h0, irq_o}, {31'h0, m_oie && m_ovf});
            chk("R12", "irq_short", {31'h0, irq_s}, {31'h0, m_sie && (m_fl != 0)});
            chk(cur_req, "rdata", rdata, exp_rd(int'(addr)));
        end
    end

    task automatic bus_write(int a, bit [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = 5'(a); wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = 32'h0;
    endtask

    task automatic read_chk(string req, int a, bit [31:0] e);
        @(negedge clk);
        addr = 5'(a);
        #1;
        chk(req, "read", rdata, e);
    endtask

    task automatic wait_cnt(int c);
        while (!(m_cnt == c && m_run)) @(negedge clk);
    endtask

    task automatic measure();
        for (int p = 0; p < NPIN; p++) hc[p] = 0;
        wait_cnt(0);
        for (int i = 0; i < PER; i++) begin
            for (int p = 0; p < NPIN; p++) if (pins[p] === 1'b1) hc[p]++;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog expired: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        wr = 0; addr = 0; wdata = 0; sh = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        read_chk("R1", 0, 0);
        read_chk("R1", 1, 0);
        read_chk("R1", 2, 0);
        read_chk("R1", 8, 0);
        chk("R1", "pins", {8'h0, pins}, 0);
        chk("R1", "irq_ovf", {31'h0, irq_o}, 0);

        // R9: configure while stopped
        cur_req = "R9";
        bus_write(8,  cfg(100,  0, 0, 1, 0));
        bus_write(9,  cfg(300,  0, 1, 2, 0));
        bus_write(10, cfg(501,  0, 2, 1, 0));
        bus_write(11, cfg(50,   0, 0, 1, 2000));
        bus_write(12, cfg(10,   1, 0, 2, 0));
        bus_write(13, cfg(500,  0, 0, 3, 0));
        bus_write(14, cfg(2047, 1, 1, 1, 0));
        bus_write(15, cfg(0,    1, 2, 2, 0));
        bus_write(16, cfg(600,  0, 3, 1, 0));
        bus_write(17, cfg(1000, 0, 2, 0, 100));
        bus_write(18, cfg(1,    0, 2, 1, 7));
        bus_write(19, cfg(2047, 0, 0, 2, 5));
        read_chk("R9", 12, cfg(10, 1, 0, 2, 0));
        chk("R2", "pins stopped", {8'h0, pins}, 0);

        cur_req = "R4";
        bus_write(0, 32'h7);
        measure();
        chk("R4", "ch0 width", hc[0], 100);
        chk("R3", "ch0 pin B", hc[1], 0);
        chk("R5", "ch1 width", hc[3], 300);
        chk("R3", "ch1 pin A", hc[2], 0);
        chk("R6", "ch2 width", hc[4], 501);
        chk("R7", "ch3 wrapped width", hc[6], 50);
        chk("R8", "ch4 even period", hc[9], 10);
        chk("R3", "ch5 mode 3 A", hc[10], 0);
        chk("R3", "ch5 mode 3 B", hc[11], 0);
        chk("R8", "ch6 even period", hc[12], 2047);
        chk("R8", "ch7 even period", hc[15], 0);
        chk("R4", "ch8 align 3", hc[16], 600);
        chk("R3", "ch9 mode 0", hc[18] + hc[19], 0);
        chk("R6", "ch10 width", hc[20], 1);
        chk("R7", "ch11 width", hc[23], 2047);

        cur_req = "R8";
        measure();
        chk("R8", "ch4 odd period", hc[9], 11);
        chk("R8", "ch6 odd period", hc[12], 2048);
        chk("R8", "ch7 odd period", hc[15], 1);

        cur_req = "R6";
        wait_cnt(772);
        chk("R6", "ch2 before lo", {31'h0, pins[4]}, 0);
        wait_cnt(773);
        chk("R6", "ch2 at lo", {31'h0, pins[4]}, 1);
        cur_req = "R7";
        wait_cnt(1999);
        chk("R7", "ch3 before delay", {31'h0, pins[6]}, 0);
        wait_cnt(2000);
        chk("R7", "ch3 at delay", {31'h0, pins[6]}, 1);

        // R10: wrap flag and clear
        cur_req = "R10";
        read_chk("R10", 1, 1);
        chk("R10", "irq_ovf set", {31'h0, irq_o}, 1);
        bus_write(1, 1);
        read_chk("R10", 1, 0);
        chk("R10", "irq_ovf cleared", {31'h0, irq_o}, 0);

        // R9: mid-period rewrite waits for the wrap
        cur_req = "R9";
        wait_cnt(300);
        bus_write(8, cfg(700, 0, 0, 1, 0));
        wait_cnt(305);
        chk("R9", "old width holds", {31'h0, pins[0]}, 0);
        read_chk("R9", 8, cfg(700, 0, 0, 1, 0));
        measure();
        chk("R9", "new width", hc[0], 700);

        // R11 / R12: short reports
        cur_req = "R11";
        @(negedge clk);
        sh = 24'h800080; addr = 5'd2;
        @(negedge clk);
        sh = 24'h0;
        @(negedge clk);
        #1;
        chk("R11", "flag after two edges", rdata, 0);
        @(negedge clk);
        #1;
        chk("R11", "flag after three edges", rdata, 32'h800080);
        chk("R12", "irq_short on", {31'h0, irq_s}, 1);
        cur_req = "R12";
        bus_write(0, 32'h3);
        @(negedge clk);
        #1;
        chk("R12", "irq_short masked", {31'h0, irq_s}, 0);
        cur_req = "R11";
        bus_write(2, 32'h80);
        read_chk("R11", 2, 32'h800000);
        bus_write(2, 32'h800000);
        read_chk("R11", 2, 0);

        // R2: stop and restart
        cur_req = "R2";
        bus_write(0, 0);
        @(negedge clk);
        chk("R2", "pins after stop", {8'h0, pins}, 0);
        bus_write(1, 1);
        bus_write(0, 1);
        addr = 5'd1;
        repeat (2047) @(negedge clk);
        #1;
        chk("R2", "no wrap before 2048", rdata, 0);
        @(negedge clk);
        #1;
        chk("R2", "wrap after 2048", rdata, 1);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule